// File: doc/BRIEF.md
# Configuration-Register Message Bus Bridge

This block lets a host reach registers on an internal sideband message network using only three 32-bit configuration-space registers: a command word, an address-extension word and a data word. Loading the extension and data words only changes stored values. Writing the command word is what starts a transaction. The command word carries an opcode, a destination port number, the low byte of the target register address and a byte-enable nibble. The bridge builds the full 32-bit register address from the upper 24 bits of the extension word and the address byte in the command word. It then drives a request on the message side and holds it until the endpoint acknowledges.

For a write, the host loads the data word, then the extension word, then the command word. For a read, the host loads the extension word and then the command word. It waits for the busy flag to clear and then reads the data word, which the bridge has loaded from the endpoint's response. A command word that arrives while a transaction is in flight is dropped. A command word with an unknown opcode causes no bus activity. Both cases set a sticky error flag.

Top module: `cfgmsg_bridge`

## Requirements
- R1: After reset all three registers read as zero, and `busy`, `err` and `req_valid` are low.
- R2: The command word is at offset 0xD0, the extension word at 0xD4 and the data word at 0xD8. All three read back what was last stored in them. Any other offset reads as zero, and a write to any other offset changes nothing.
- R3: A write to the extension or data offset stores its value and never raises `req_valid`.
- R4: A command write with a legal opcode, accepted while `busy` is low, drives `req_valid` and `busy` high on the next cycle. The request then carries opcode = bits 31:24, port = bits 23:16, byte enables = bits 7:4 and address = {extension bits 31:8, command bits 15:8}. The extension low byte and the command bits 3:0 are ignored.
- R5: The legal opcodes are 0x10/0x11 (normal), 0x06/0x07 (alternate) and 0x02/0x03 (I/O). Opcode bit 0 set means write, and `req_write` follows it. A write request carries the data word as `req_wdata`.
- R6: The request fields are captured at launch. They stay stable while `req_valid` is high and `rsp_ack` is low, even if the extension or data word is rewritten during that time.
- R7: On the cycle after `req_valid` and `rsp_ack` are both high, `req_valid` and `busy` are low. A read has loaded `rsp_rdata` into the data word. A write leaves the data word unchanged.
- R8: A command write while `busy` is high leaves the command word unchanged, starts no request and sets `err`.
- R9: A command write with any other opcode is stored but raises neither `req_valid` nor `busy`, and it sets `err` on the next cycle.
- R10: `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the offset on `host_addr` |
| busy | output | 1 | Transaction in flight |
| err | output | 1 | Sticky error flag |
| req_valid | output | 1 | Message request valid |
| req_opcode | output | 8 | Request opcode |
| req_port | output | 8 | Destination port number |
| req_addr | output | 32 | Full register address |
| req_be | output | 4 | Byte enables |
| req_write | output | 1 | Request is a write |
| req_wdata | output | 32 | Write data |
| rsp_ack | input | 1 | Endpoint acknowledge |
| rsp_rdata | input | 32 | Endpoint read data, valid with `rsp_ack` |

## Verification
The bench sweeps all 256 opcode values. Each opcode gets its own port number, address byte and extension value, and the extension low byte and command low nibble are filled with junk. This separates the six legal opcodes from every neighbour that differs in one bit, and separates read from write by the direction bit. It also exposes any mixing of the ignored bits into the address or byte enables. Acknowledge delays of zero to three cycles show whether the request holds steady while waiting. Readback of the data word shows whether the response is loaded for reads only. A separate run rewrites the command, extension and data words while a request is waiting. This tells a dropped collision and captured request fields apart from a design that relaunches or tracks the live registers.

// File: rtl/cfgmsg_pkg.sv
package cfgmsg_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 8;
  localparam int OP_W   = 8;
  localparam int PORT_W = 8;
  localparam int BE_W   = 4;

  // opcode pairs: bit 0 selects write
  localparam logic [OP_W-1:0] OP_NRM_RD = 8'h10;
  localparam logic [OP_W-1:0] OP_ALT_RD = 8'h06;
  localparam logic [OP_W-1:0] OP_IO_RD  = 8'h02;

  typedef struct packed {
    logic [OP_W-1:0]   opcode;
    logic [PORT_W-1:0] port;
    logic [WORD_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic              write;
    logic [WORD_W-1:0] wdata;
  } msg_req_t;

  function automatic logic op_is_legal(input logic [OP_W-1:0] op);
    logic [OP_W-1:0] base;
    base = {op[OP_W-1:1], 1'b0};
    return (base == OP_NRM_RD) || (base == OP_ALT_RD) || (base == OP_IO_RD);
  endfunction
endpackage

// File: rtl/cfgmsg_opdec.sv
module cfgmsg_opdec
  import cfgmsg_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic            legal,
  output logic            is_write
);
  always_comb begin
    legal    = op_is_legal(opcode);
    is_write = opcode[0];
  end
endmodule

// File: rtl/cfgmsg_regs.sv
module cfgmsg_regs
  import cfgmsg_pkg::*;
#(
  parameter logic [OFS_W-1:0] CMD_OFS  = 8'hD0,
  parameter logic [OFS_W-1:0] EXT_OFS  = 8'hD4,
  parameter logic [OFS_W-1:0] DATA_OFS = 8'hD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              busy,
  input  logic              rsp_load,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              cmd_hit,
  output logic [WORD_W-1:0] ext_q,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] host_rdata
);
  logic [WORD_W-1:0] cmd_q, cmd_d, ext_d, data_d;
  logic cmd_en, ext_en, data_en;
  logic ext_hit, data_hit;

  always_comb begin
    cmd_hit  = host_wr && (host_addr == CMD_OFS);
    ext_hit  = host_wr && (host_addr == EXT_OFS);
    data_hit = host_wr && (host_addr == DATA_OFS);
    cmd_en   = cmd_hit && !busy;
    ext_en   = ext_hit;
    data_en  = rsp_load || data_hit;
    cmd_d    = host_wdata;
    ext_d    = host_wdata;
    data_d   = rsp_load ? rsp_data : host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ext_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_en)  cmd_q  <= cmd_d;
      if (ext_en)  ext_q  <= ext_d;
      if (data_en) data_q <= data_d;
    end
  end

  always_comb begin
    unique case (host_addr)
      CMD_OFS:  host_rdata = cmd_q;
      EXT_OFS:  host_rdata = ext_q;
      DATA_OFS: host_rdata = data_q;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfgmsg_seq.sv
module cfgmsg_seq
  import cfgmsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_hit,
  input  logic     op_legal,
  input  msg_req_t req_in,
  input  logic     rsp_ack,
  output logic     busy,
  output logic     err,
  output logic     rsp_load,
  output msg_req_t req_q
);
  logic     busy_d, err_d, launch, finish, req_en;
  msg_req_t req_d;

  always_comb begin
    launch   = cmd_hit && !busy && op_legal;
    finish   = busy && rsp_ack;
    rsp_load = finish && !req_q.write;
    busy_d   = launch ? 1'b1 : (finish ? 1'b0 : busy);
    err_d    = err || (cmd_hit && (busy || !op_legal));
    req_en   = launch;
    req_d    = req_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      err   <= 1'b0;
      req_q <= '0;
    end else begin
      busy <= busy_d;
      err  <= err_d;
      if (req_en) req_q <= req_d;
    end
  end
endmodule

// File: rtl/cfgmsg_bridge.sv
module cfgmsg_bridge
  import cfgmsg_pkg::*;
#(
  parameter logic [7:0] CMD_OFS  = 8'hD0,
  parameter logic [7:0] EXT_OFS  = 8'hD4,
  parameter logic [7:0] DATA_OFS = 8'hD8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        busy,
  output logic        err,
  output logic        req_valid,
  output logic [7:0]  req_opcode,
  output logic [7:0]  req_port,
  output logic [31:0] req_addr,
  output logic [3:0]  req_be,
  output logic        req_write,
  output logic [31:0] req_wdata,
  input  logic        rsp_ack,
  input  logic [31:0] rsp_rdata
);
  localparam int ABYTE_LO = 8;

  logic              cmd_hit, op_legal, op_write, rsp_load, busy_i;
  logic [WORD_W-1:0] ext_q, data_q;
  msg_req_t          req_in, req_q;

  cfgmsg_regs #(
    .CMD_OFS(CMD_OFS), .EXT_OFS(EXT_OFS), .DATA_OFS(DATA_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy_i), .rsp_load(rsp_load),
    .rsp_data(rsp_rdata), .cmd_hit(cmd_hit), .ext_q(ext_q),
    .data_q(data_q), .host_rdata(host_rdata)
  );

  cfgmsg_opdec u_opdec (
    .opcode(host_wdata[31:24]), .legal(op_legal), .is_write(op_write)
  );

  always_comb begin
    req_in.opcode = host_wdata[31:24];
    req_in.port   = host_wdata[23:16];
    req_in.addr   = {ext_q[WORD_W-1:ABYTE_LO], host_wdata[15:8]};
    req_in.be     = host_wdata[7:4];
    req_in.write  = op_write;
    req_in.wdata  = data_q;
  end

  cfgmsg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .op_legal(op_legal),
    .req_in(req_in), .rsp_ack(rsp_ack), .busy(busy_i), .err(err),
    .rsp_load(rsp_load), .req_q(req_q)
  );

  always_comb begin
    busy       = busy_i;
    req_valid  = busy_i;
    req_opcode = req_q.opcode;
    req_port   = req_q.port;
    req_addr   = req_q.addr;
    req_be     = req_q.be;
    req_write  = req_q.write;
    req_wdata  = req_q.wdata;
  end
endmodule

// File: rtl/cfgmsg_bridge_chk.sv
module cfgmsg_bridge_chk
  import cfgmsg_pkg::*;
#(
  parameter logic [7:0] CMD_OFS = 8'hD0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [7:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic        busy,
  input logic        err,
  input logic        req_valid,
  input logic [7:0]  req_opcode,
  input logic [7:0]  req_port,
  input logic [31:0] req_addr,
  input logic [3:0]  req_be,
  input logic        req_write,
  input logic [31:0] req_wdata,
  input logic        rsp_ack
);
  logic cmd_wr;
  assign cmd_wr = host_wr && (host_addr == CMD_OFS);

  AST_QUIET_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !cmd_wr && !req_valid) |=> !req_valid); // R3
  AST_LAUNCH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && op_is_legal(host_wdata[31:24])) |=>
      (req_valid && busy && req_opcode == $past(host_wdata[31:24]) &&
       req_port == $past(host_wdata[23:16]) && req_be == $past(host_wdata[7:4]) &&
       req_addr[7:0] == $past(host_wdata[15:8]))); // R4
  AST_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> op_is_legal(req_opcode)); // R5
  AST_DIR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_write == req_opcode[0])); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_ack) |=> (req_valid && $stable(req_addr) &&
      $stable(req_opcode) && $stable(req_port) && $stable(req_wdata) && $stable(req_be))); // R6
  AST_ACK_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_ack) |=> (!req_valid && !busy)); // R7
  AST_COLLIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> err); // R8
  AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !op_is_legal(host_wdata[31:24])) |=> (!req_valid && err)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10
endmodule

bind cfgmsg_bridge cfgmsg_bridge_chk #(.CMD_OFS(CMD_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .busy(busy), .err(err), .req_valid(req_valid),
  .req_opcode(req_opcode), .req_port(req_port), .req_addr(req_addr),
  .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
  .rsp_ack(rsp_ack)
);

// File: tb/cfgmsg_bridge_tb.sv
`timescale 1ns/1ps
module cfgmsg_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy, err, req_valid, req_write, rsp_ack = 1'b0;
  logic [7:0]  req_opcode, req_port;
  logic [31:0] req_addr, req_wdata, rsp_rdata = '0;
  logic [3:0]  req_be;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic exp_err = 1'b0;

  always #10 clk = ~clk;

  cfgmsg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .err(err),
    .req_valid(req_valid), .req_opcode(req_opcode), .req_port(req_port),
    .req_addr(req_addr), .req_be(req_be), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic ack(input logic [31:0] d);
    rsp_ack = 1'b1; rsp_rdata = d;
    @(negedge clk);
    rsp_ack = 1'b0; rsp_rdata = '0;
  endtask

  function automatic bit legal(input logic [7:0] op);
    return op == 8'h02 || op == 8'h03 || op == 8'h06 || op == 8'h07 ||
           op == 8'h10 || op == 8'h11;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_addr;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'hD0, v); chk("R1 cmd", v, 0);
    rd(8'hD4, v); chk("R1 ext", v, 0);
    rd(8'hD8, v); chk("R1 data", v, 0);
    chk("R1 flags", {busy, err, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 map and quiet storage writes
    wr(8'hD4, 32'hA1B2_C3D4); chk("R3 ext no req", req_valid, 0);
    wr(8'hD8, 32'h1357_9BDF); chk("R3 data no req", req_valid, 0);
    repeat (2) @(negedge clk);
    chk("R3 still idle", {req_valid, busy}, 0);
    wr(8'hDC, 32'hFFFF_FFFF);
    rd(8'hDC, v); chk("R2 unmapped reads 0", v, 0);
    rd(8'hD4, v); chk("R2 ext readback", v, 32'hA1B2_C3D4);
    rd(8'hD8, v); chk("R2 data readback", v, 32'h1357_9BDF);
    rd(8'hD0, v); chk("R2 cmd untouched", v, 0);
    chk("R2 err clear", err, 0);

    // R6 / R8 collision while busy
    wr(8'hD4, 32'h0BAD_0000);
    wr(8'hD0, 32'h1022_44F0);
    exp_addr = 32'h0BAD_0044;
    chk("R4 launch", {req_valid, busy}, 2'b11);
    chk("R8 err before", err, 0);
    wr(8'hD0, 32'h1199_88F0);
    chk("R8 err set", err, 1);
    exp_err = 1'b1;
    wr(8'hD4, 32'hFFFF_FF00);
    wr(8'hD8, 32'h7777_7777);
    chk("R6 addr held", req_addr, exp_addr);
    chk("R8 op held", req_opcode, 8'h10);
    rd(8'hD0, v); chk("R8 cmd unchanged", v, 32'h1022_44F0);
    ack(32'hFEED_F00D);
    chk("R7 idle after ack", {req_valid, busy}, 0);
    rd(8'hD8, v); chk("R7 read data loaded", v, 32'hFEED_F00D);

    // sweep every opcode value
    for (int op = 0; op < 256; op++) begin
      logic [7:0]  o, pt, rb;
      logic [31:0] ex, dv, cw, rdv;
      o  = 8'(op);
      pt = o ^ 8'h5A;
      rb = ~o;
      ex = {8'h12 ^ o, 8'h34, o, 8'hFF};
      dv = 32'hC0DE_0000 | 32'(op);
      cw = {o, pt, rb, 4'hF, 4'h9};
      wr(8'hD8, dv);
      wr(8'hD4, ex);
      chk("R3 no req", req_valid, 0);
      wr(8'hD0, cw);
      rd(8'hD0, v); chk("R9 cmd stored", v, cw);
      if (legal(o)) begin
        exp_addr = {ex[31:8], rb};
        chk("R4 valid", {req_valid, busy}, 2'b11);
        chk("R4 opcode", req_opcode, o);
        chk("R4 port", req_port, pt);
        chk("R4 addr", req_addr, exp_addr);
        chk("R4 be", req_be, 4'hF);
        chk("R5 dir", req_write, o[0]);
        if (o[0]) chk("R5 wdata", req_wdata, dv);
        for (int w = 0; w < op % 4; w++) begin
          @(negedge clk);
          chk("R6 hold", {31'd0, req_valid}, 1);
          chk("R6 addr", req_addr, exp_addr);
        end
        rdv = exp_addr ^ 32'h5A5A_5A5A;
        ack(rdv);
        chk("R7 done", {req_valid, busy}, 0);
        rd(8'hD8, v);
        chk("R7 data", v, o[0] ? dv : rdv);
        chk("R10 err", err, exp_err);
      end else begin
        @(negedge clk);
        chk("R9 no req", {req_valid, busy}, 0);
        exp_err = 1'b1;
        chk("R9 err", err, 1);
      end
    end

    // R1 / R10 reset clears error
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 err cleared by reset", err, 0);
    rd(8'hD8, v); chk("R1 data cleared", v, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule